// File: doc/BRIEF.md
# Layered Programmable Lookup-Table Fabric with Fault Injection

This block is a feed-forward array of programmable k-input lookup-table gates arranged in three layers. Each gate holds a truth-table register, one wire-select index for each of its inputs, and a stuck flag. Every wire index picks one bit from the output vector of the layer below it. Any bit may feed any number of gates. The first layer reads the global input vector. The fabric evaluates the input combinationally through all layers, and the first `N_OUT` gates of the last layer are captured in an output register.

A single configuration port writes truth tables and wire indices, and it also injects damage. Two damage models are available. A soft error XORs a mask into a gate's truth table, and a later truth-table write replaces the corrupted contents in full. A stuck-at fault clamps the gate output to 0. Configuration writes and initialisation do not clear it. Only the global reset removes it.

A one-shot initialise command loads every truth table as an identity pass-through of one of that gate's own inputs. The input is chosen round-robin by gate position. A small controller with two states, `ST_IDLE` and `ST_SWEEP`, sequences the command. `ST_IDLE` moves to `ST_SWEEP` when `init_req` is high, and the layer counter starts at 0. `ST_SWEEP` loads one layer per cycle and returns to `ST_IDLE` after the last layer. While the sweep runs, configuration writes are dropped.

Top module: `lut_fabric`

## Requirements
- R1: After reset every truth table, every wire index and every stuck flag is 0, and `out_vec` reads 0 for any input.
- R2: A gate's output is its truth-table bit at address {sel[K-1],...,sel[0]}, where sel[i] is the bit chosen by input i. Input 0 is the address LSB.
- R3: Each gate input reads the bit of the previous layer's output (the global input for layer 0) chosen by its wire index. One bit may fan out to several gates.
- R4: A wire index equal to or greater than the previous layer's width (12 for layer 0, 96 for layers 1 and 2 by default) reads as 0.
- R5: `out_vec[j]` is a register holding gate j of the last layer. It reflects the input present before a rising edge and does not change between edges.
- R6: When `cfg_valid` is high and no sweep is running, one write is applied at the edge to gate `cfg_gate` of layer `cfg_layer`. The write is selected by `cfg_kind`: 0 loads the truth table from `cfg_data[15:0]`; 1 sets the wire index of input `cfg_data[8:7]` to `cfg_data[6:0]`; 2 flips truth-table bits; 3 sets the stuck flag. A truth table changes only through a write or a sweep.
- R7: Kind 2 XORs `cfg_data[15:0]` into the truth table. A later kind-0 write to that gate replaces the corrupted contents in full.
- R8: A stuck gate outputs 0, and the 0 propagates downstream. Truth-table writes and the initialise sweep keep the flag set, and only reset clears it.
- R9: The initialise sweep loads gate g of each layer with the identity of input g mod K. For K=4 the patterns are 0xAAAA, 0xCCCC, 0xF0F0 and 0xFF00. Wire indices are left unchanged.
- R10: A pulse on `init_req` in `ST_IDLE` holds `init_busy` high for exactly three cycles, one layer per cycle. `init_req` and configuration writes that arrive during the sweep are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous global reset |
| in_vec | input | 12 | Global input vector |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_layer | input | 2 | Target layer (0 to 2) |
| cfg_gate | input | 7 | Target gate within the layer |
| cfg_kind | input | 2 | Write kind: 0 table, 1 wire, 2 flip, 3 stuck |
| cfg_data | input | 16 | Write data word |
| init_req | input | 1 | Start the round-robin identity sweep |
| init_busy | output | 1 | Sweep in progress |
| out_vec | output | 12 | Registered outputs of the first 12 last-layer gates |

## Verification
The assertions assume that `rst_n` is applied before any configuration and that `cfg_kind` always carries one of the four defined codes. The stuck-flag and table-stability properties also take as given that a gate is addressed by at most one write per cycle. The bench holds to these assumptions. It drives every write for a single cycle from a task, starts each phase from a reset, and pulses `init_req` only when the bench intends a sweep or wants to test a request during the sweep. Wire indices above 95 are used only on purpose, to test the out-of-range rule.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;

    // Configuration write kinds
    typedef enum logic [1:0] {
        WR_TABLE = 2'd0,
        WR_WIRE  = 2'd1,
        WR_FLIP  = 2'd2,
        WR_STUCK = 2'd3
    } wr_kind_e;

    // Initialise sequencer states
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lutfab_init_fsm.sv
module lutfab_init_fsm
    import lutfab_pkg::*;
#(
    parameter int NL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_req,
    output logic          busy,
    output logic [NL-1:0] load_vec
);
    localparam int CW = (NL > 2) ? $clog2(NL) : 1;
    localparam logic [CW-1:0] LAST = CW'(NL - 1);

    sweep_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (init_req) begin
                    state_d = ST_SWEEP;
                    cnt_d   = '0;
                end
            end
            ST_SWEEP: begin
                if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_SWEEP);
        for (int i = 0; i < NL; i++) begin
            load_vec[i] = busy && (cnt_q == CW'(i));
        end
    end

    p_sweep_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + CW'(1)));

    p_sweep_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == LAST) |=> !busy);

    p_one_layer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec));

endmodule

// File: rtl/lutfab_gate.sv
module lutfab_gate
    import lutfab_pkg::*;
#(
    parameter int K      = 4,
    parameter int IDX_W  = 7,
    parameter int BUS_W  = 96,
    parameter int DATA_W = 16,
    parameter int SEL    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_kind_e          wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              init_load,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              y,
    output logic              stuck_o
);
    localparam int TBL  = 1 << K;
    localparam int KW   = $clog2(K);
    localparam int SPAN = 1 << IDX_W;
    localparam int PAD  = SPAN - BUS_W;

    function automatic logic [TBL-1:0] ident_table();
        logic [TBL-1:0] t;
        for (int a = 0; a < TBL; a++) begin
            t[a] = ((a >> SEL) & 1) != 0;
        end
        return t;
    endfunction

    localparam logic [TBL-1:0] IDENT = ident_table();

    logic [TBL-1:0]   table_q;
    logic [IDX_W-1:0] wsel_q [K];
    logic             stuck_q;
    logic [SPAN-1:0]  padded;
    logic [K-1:0]     addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            table_q <= '0;
            stuck_q <= 1'b0;
            for (int i = 0; i < K; i++) begin
                wsel_q[i] <= '0;
            end
        end else if (init_load) begin
            table_q <= IDENT;
        end else if (wr_en) begin
            unique case (wr_kind)
                WR_TABLE: table_q <= wr_data[TBL-1:0];
                WR_WIRE:  wsel_q[wr_data[IDX_W +: KW]] <= wr_data[IDX_W-1:0];
                WR_FLIP:  table_q <= table_q ^ wr_data[TBL-1:0];
                WR_STUCK: stuck_q <= 1'b1;
            endcase
        end
    end

    // indices past the previous layer land in the zero padding
    assign padded = {{PAD{1'b0}}, bus_in};

    always_comb begin
        for (int i = 0; i < K; i++) begin
            addr[i] = padded[wsel_q[i]];
        end
    end

    assign y       = stuck_q ? 1'b0 : table_q[addr];
    assign stuck_o = stuck_q;

    p_stuck_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_q |=> stuck_q);

    p_table_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !init_load) |=> $stable(table_q));

endmodule

// File: rtl/lutfab_layer.sv
module lutfab_layer
    import lutfab_pkg::*;
#(
    parameter int LAYER   = 0,
    parameter int WIDTH   = 96,
    parameter int KEEP    = 96,
    parameter int K       = 4,
    parameter int IDX_W   = 7,
    parameter int BUS_W   = 96,
    parameter int GATE_W  = 7,
    parameter int LAYER_W = 2,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [LAYER_W-1:0] cfg_layer,
    input  logic [GATE_W-1:0]  cfg_gate,
    input  wr_kind_e           cfg_kind,
    input  logic [DATA_W-1:0]  cfg_data,
    input  logic               init_load,
    input  logic [BUS_W-1:0]   bus_in,
    output logic [KEEP-1:0]    y_out
);
    logic [WIDTH-1:0] gate_y;
    logic [WIDTH-1:0] gate_stuck;
    logic             layer_hit;

    assign layer_hit = cfg_en && (cfg_layer == LAYER_W'(LAYER));

    for (genvar g = 0; g < WIDTH; g++) begin : g_gate
        logic hit;
        assign hit = layer_hit && (cfg_gate == GATE_W'(g));

        lutfab_gate #(
            .K      (K),
            .IDX_W  (IDX_W),
            .BUS_W  (BUS_W),
            .DATA_W (DATA_W),
            .SEL    (g % K)
        ) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (hit),
            .wr_kind   (cfg_kind),
            .wr_data   (cfg_data),
            .init_load (init_load),
            .bus_in    (bus_in),
            .y         (gate_y[g]),
            .stuck_o   (gate_stuck[g])
        );

        p_stuck_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
            gate_stuck[g] |-> !gate_y[g]);
    end

    assign y_out = gate_y[KEEP-1:0];

endmodule

// File: rtl/lut_fabric.sv
module lut_fabric
    import lutfab_pkg::*;
#(
    parameter int N_IN  = 12,
    parameter int K     = 4,
    parameter int W_L0  = 96,
    parameter int W_L1  = 96,
    parameter int W_L2  = 48,
    parameter int N_OUT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_vec,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_layer,
    input  logic [6:0]       cfg_gate,
    input  logic [1:0]       cfg_kind,
    input  logic [15:0]      cfg_data,
    input  logic             init_req,
    output logic             init_busy,
    output logic [N_OUT-1:0] out_vec
);
    localparam int NL      = 3;
    localparam int LAYER_W = 2;
    localparam int BUS_W   = imax(N_IN, imax(W_L0, W_L1));
    localparam int IDX_W   = $clog2(BUS_W + 1);
    localparam int GATE_W  = 7;
    localparam int DATA_W  = 16;

    function automatic int width_of(input int l);
        return (l == 0) ? W_L0 : ((l == 1) ? W_L1 : W_L2);
    endfunction

    logic [BUS_W-1:0] bus [NL];
    logic [N_OUT-1:0] final_vec;
    logic [NL-1:0]    load_vec;
    logic             cfg_en;
    logic [N_OUT-1:0] out_q;

    assign cfg_en = cfg_valid && !init_busy;
    assign bus[0] = BUS_W'(in_vec);

    lutfab_init_fsm #(.NL(NL)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (init_req),
        .busy     (init_busy),
        .load_vec (load_vec)
    );

    for (genvar l = 0; l < NL; l++) begin : g_layer
        localparam int W    = width_of(l);
        localparam int KEEP = (l == NL - 1) ? N_OUT : W;
        logic [KEEP-1:0] lo;

        lutfab_layer #(
            .LAYER   (l),
            .WIDTH   (W),
            .KEEP    (KEEP),
            .K       (K),
            .IDX_W   (IDX_W),
            .BUS_W   (BUS_W),
            .GATE_W  (GATE_W),
            .LAYER_W (LAYER_W),
            .DATA_W  (DATA_W)
        ) u_layer (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_en    (cfg_en),
            .cfg_layer (cfg_layer),
            .cfg_gate  (cfg_gate),
            .cfg_kind  (wr_kind_e'(cfg_kind)),
            .cfg_data  (cfg_data),
            .init_load (load_vec[l]),
            .bus_in    (bus[l]),
            .y_out     (lo)
        );

        if (l < NL - 1) begin : g_fwd
            assign bus[l+1] = BUS_W'(lo);
        end else begin : g_last
            assign final_vec = lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= final_vec;
        end
    end

    assign out_vec = out_q;

    p_quiet_in_sweep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && !load_vec[NL-1]) |=> init_busy);

endmodule

// File: tb/lut_fabric_bench.sv
module lut_fabric_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] in_vec = '0;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_layer = '0;
    logic [6:0]  cfg_gate = '0;
    logic [1:0]  cfg_kind = '0;
    logic [15:0] cfg_data = '0;
    logic        init_req = 1'b0;
    logic        init_busy;
    logic [11:0] out_vec;

    int checks = 0;
    int errors = 0;

    // expected-value model state
    logic        t3_on = 1'b0;
    logic        b6_on = 1'b0;
    logic [15:0] tbl_c = 16'hB38D;
    logic [11:0] inv_m = '0;
    logic [11:0] ones_m = '0;
    logic [11:0] zeros_m = '0;

    always #2.5 clk = ~clk;

    lut_fabric u_lut_fabric (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vec    (in_vec),
        .cfg_valid (cfg_valid),
        .cfg_layer (cfg_layer),
        .cfg_gate  (cfg_gate),
        .cfg_kind  (cfg_kind),
        .cfg_data  (cfg_data),
        .init_req  (init_req),
        .init_busy (init_busy),
        .out_vec   (out_vec)
    );

    function automatic logic [11:0] rev12(input logic [11:0] v);
        logic [11:0] r;
        for (int i = 0; i < 12; i++) r[i] = v[11-i];
        return r;
    endfunction

    function automatic logic [11:0] model(input logic [11:0] v);
        logic [11:0] r;
        r = rev12(v);
        if (t3_on) r[0] = tbl_c[v[3:0]];
        if (b6_on) r[6] = v[7];
        r = r ^ inv_m;
        r = r | ones_m;
        r = r & ~zeros_m;
        return r;
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input int l, input int g, input int kind, input logic [15:0] d);
        cfg_valid = 1'b1;
        cfg_layer = 2'(l);
        cfg_gate  = 7'(g);
        cfg_kind  = 2'(kind);
        cfg_data  = d;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic wr_wire(input int l, input int g, input int slot, input int idx);
        wr(l, g, 1, 16'((slot << 7) | idx));
    endtask

    task automatic sweep(input string tag, input int n);
        for (int v = 0; v < n; v++) begin
            in_vec = 12'(v);
            @(negedge clk);
            check(tag, out_vec, model(12'(v)));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: empty fabric yields zero
        in_vec = 12'hFFF;
        @(negedge clk);
        check("R1 reset output", out_vec, 12'h000);

        // bit-reversal chain through three layers (R6 writes)
        for (int g = 0; g < 12; g++) begin
            wr(0, g, 0, 16'hAAAA); wr_wire(0, g, 0, g);
            wr(1, g, 0, 16'hAAAA); wr_wire(1, g, 0, g);
            wr(2, g, 0, 16'hAAAA); wr_wire(2, g, 0, 11 - g);
        end
        sweep("R3 R6 reversal chain", 4096);

        // R5: registered output timing
        in_vec = 12'h001;
        @(negedge clk);
        check("R5 capture", out_vec, 12'h800);
        in_vec = 12'h002;
        #1;
        check("R5 hold between edges", out_vec, 12'h800);
        @(negedge clk);
        check("R5 next capture", out_vec, 12'h400);

        // R2: address order, R3 fan-out of layer1 gate0
        for (int s = 0; s < 4; s++) wr_wire(2, 0, s, s);
        wr(2, 0, 0, tbl_c);
        t3_on = 1'b1;
        sweep("R2 table address", 4096);

        // R4: boundary wire indices
        wr(1, 95, 0, 16'hAAAA); wr_wire(1, 95, 0, 7);
        wr_wire(2, 6, 0, 95);
        b6_on = 1'b1;
        wr(2, 5, 0, 16'h5555); wr_wire(2, 5, 0, 96);
        wr(0, 10, 0, 16'h5555); wr_wire(0, 10, 0, 12);
        ones_m = 12'h022;
        sweep("R4 index range", 4096);

        // R7: soft error then repair
        wr(2, 2, 2, 16'hFFFF);
        inv_m = 12'h004;
        sweep("R7 flip", 4096);
        wr(2, 2, 0, 16'hAAAA);
        inv_m = '0;
        sweep("R7 overwrite", 1024);

        // R8: stuck clamps survive table writes and propagate
        wr(2, 3, 3, 16'h0000);
        wr(2, 3, 0, 16'hFFFF);
        wr(0, 4, 3, 16'h0000);
        zeros_m = 12'h088;
        sweep("R8 stuck", 4096);

        // R1/R8: reset clears stuck
        do_reset();
        in_vec = 12'hFFF;
        @(negedge clk);
        check("R1 second reset", out_vec, 12'h000);
        wr(2, 3, 0, 16'hFFFF);
        @(negedge clk);
        check("R8 reset clears stuck", out_vec, 12'h008);

        // R9/R10: round-robin identity sweep
        t3_on = 1'b0; b6_on = 1'b0; ones_m = '0; inv_m = '0;
        for (int g = 0; g < 12; g++) begin
            wr_wire(0, g, g % 4, g);
            wr_wire(1, g, g % 4, g);
            wr_wire(2, g, g % 4, 11 - g);
        end
        wr(1, 2, 3, 16'h0000);
        zeros_m = 12'h200;
        check("R10 idle before sweep", 12'(init_busy), 12'h000);
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        begin
            int busy_n;
            busy_n = 0;
            while (init_busy) begin
                busy_n++;
                if (busy_n == 1) begin
                    init_req  = 1'b1;
                    cfg_valid = 1'b1;
                    cfg_layer = 2'd2;
                    cfg_gate  = 7'd0;
                    cfg_kind  = 2'd1;
                    cfg_data  = 16'd127;
                end else begin
                    init_req  = 1'b0;
                    cfg_valid = 1'b0;
                end
                @(negedge clk);
            end
            init_req  = 1'b0;
            cfg_valid = 1'b0;
            check("R10 busy length", 12'(busy_n), 12'd3);
        end
        sweep("R9 R10 identity sweep", 4096);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule